// File: doc/BRIEF.md
# Timer Interrupt Flag Registers

This block keeps the sticky status flags of an eight-channel timer. It has two byte-wide flag registers on a small register bus. The first holds one capture/compare flag per channel. The second holds the counter overflow flag in its top bit. Single-cycle event pulses from the channels and from the counter set the flags. The flags then stay set until software clears them.

Software clears a flag by writing a one to its bit, but only while the timer is enabled. A write of zero leaves the bit as it is. An optional fast-clear mode also clears flags as a side effect of normal traffic:
- Reading a capture channel's data register clears that channel's flag.
- Writing a compare channel's data register clears that channel's flag.
- Any access to the counter clears the overflow flag.

Each flag drives its own status output, and a combined request output feeds the interrupt logic.

Top module: `tmr_flag_regs`

## Requirements
- R1: After reset, offset 0x0E and offset 0x0F both read 0x00, and `irq_any_o` is 0.
- R2: A one on `chan_evt_i[x]` in a cycle sets the channel flag for channel x at the next clock edge. The flag is visible on bit x of offset 0x0E and on `chan_flag_o[x]`.
- R3: With `tmr_en_i` = 1, a write to 0x0E clears every channel flag whose data bit is 1. Zero bits leave their flags unchanged.
- R4: With `tmr_en_i` = 0, writes to 0x0E or 0x0F change no flag.
- R5: A one on `ovf_evt_i` sets the overflow flag at the next edge. It reads on bit 7 of offset 0x0F, and bits 6..0 of 0x0F always read 0.
- R6: With `tmr_en_i` = 1, writing 0x0F with bit 7 = 1 clears the overflow flag. Writing 0x0F with bit 7 = 0 leaves it set.
- R7: With `fast_clr_i` = 1 and `chan_is_cap_i[x]` = 1, a read of offset 0x10+2x or 0x11+2x clears flag x, and a write there does not. With `fast_clr_i` = 0, no data register access clears any flag.
- R8: With `fast_clr_i` = 1 and `chan_is_cap_i[x]` = 0, a write of offset 0x10+2x or 0x11+2x clears flag x, and a read there does not.
- R9: With `fast_clr_i` = 1, a read or write of offset 0x04 or 0x05 clears the overflow flag. With `fast_clr_i` = 0, such accesses leave it set.
- R10: When a set event and any clear request hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_any_o` is 1 exactly when at least one channel flag or the overflow flag is set.
- R12: Reading a flag register returns its value in the same cycle and does not change any flag. Offsets outside 0x0E and 0x0F read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| chan_evt_i | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| chan_is_cap_i | input | 8 | 1 = channel in capture mode, 0 = compare mode |
| tmr_en_i | input | 1 | Timer enable; gates write-one clearing |
| fast_clr_i | input | 1 | Enables clearing on data/counter access |
| chan_flag_o | output | 8 | Channel flag status |
| ovf_flag_o | output | 1 | Overflow flag status |
| irq_any_o | output | 1 | OR of all flags |

## Verification
Read data is combinational, so the bench samples `rdata_o` 1 ns after it drives a read, within the same cycle. Every flag change, whether a set by an event, a write-one clear or a fast clear, takes effect at the first rising edge after the stimulus. The bench therefore drives each stimulus on a falling edge and releases it on the next falling edge. It checks the result with a read in the following cycle, one edge after the cause. Events that coincide with clears are driven in that same single cycle, so the set-over-clear priority is seen at exactly that edge.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned FLG_DW = 8;
  localparam int unsigned FLG_AW = 5;
  localparam logic [FLG_AW-1:0] OFS_CH_FLG  = 5'h0E;
  localparam logic [FLG_AW-1:0] OFS_OVF_FLG = 5'h0F;
  localparam logic [FLG_AW-1:0] OFS_CNT_HI  = 5'h04;
  localparam logic [FLG_AW-1:0] OFS_CNT_LO  = 5'h05;
  localparam logic [FLG_AW-1:0] OFS_CH_DATA = 5'h10;
  localparam int unsigned OVF_BIT = 7;
endpackage

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/tmr_fast_clr_dec.sv
module tmr_fast_clr_dec
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned AW     = FLG_AW
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              fast_en_i,
  input  logic [NUM_CH-1:0] is_cap_i,
  output logic [NUM_CH-1:0] ch_clr_o,
  output logic              ovf_clr_o
);
  logic cnt_hit;
  assign cnt_hit   = (addr_i == AW'(OFS_CNT_HI)) || (addr_i == AW'(OFS_CNT_LO));
  assign ovf_clr_o = fast_en_i && cnt_hit && (rd_i || wr_i);

  for (genvar x = 0; x < NUM_CH; x++) begin : g_ch
    localparam logic [AW-1:0] SLOT = AW'(OFS_CH_DATA) + AW'(2 * x);
    logic hit, act;
    // either byte of the two-byte slot
    assign hit = (addr_i[AW-1:1] == SLOT[AW-1:1]);
    assign act = is_cap_i[x] ? rd_i : wr_i;
    assign ch_clr_o[x] = fast_en_i && hit && act;
  end
endmodule

// File: rtl/tmr_flag_regs.sv
module tmr_flag_regs
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned AW     = FLG_AW,
  parameter int unsigned DW     = FLG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] chan_evt_i,
  input  logic              ovf_evt_i,
  input  logic [NUM_CH-1:0] chan_is_cap_i,
  input  logic              tmr_en_i,
  input  logic              fast_clr_i,
  output logic [NUM_CH-1:0] chan_flag_o,
  output logic              ovf_flag_o,
  output logic              irq_any_o
);
  localparam int unsigned OVF_POS = (OVF_BIT < DW) ? OVF_BIT : DW - 1;

  logic              sel_ch, sel_ovf;
  logic [NUM_CH-1:0] ch_wclr, ch_fclr;
  logic              ovf_wclr, ovf_fclr;
  logic [0:0]        ovf_q;

  assign sel_ch  = (addr_i == AW'(OFS_CH_FLG));
  assign sel_ovf = (addr_i == AW'(OFS_OVF_FLG));

  assign ch_wclr  = (wr_i && sel_ch && tmr_en_i) ? wdata_i[NUM_CH-1:0] : '0;
  assign ovf_wclr = wr_i && sel_ovf && tmr_en_i && wdata_i[OVF_POS];

  tmr_fast_clr_dec #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .fast_en_i (fast_clr_i),
    .is_cap_i  (chan_is_cap_i),
    .ch_clr_o  (ch_fclr),
    .ovf_clr_o (ovf_fclr)
  );

  tmr_flag_bank #(.W(NUM_CH)) u_ch_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chan_evt_i),
    .clr_i  (ch_wclr | ch_fclr),
    .q_o    (chan_flag_o)
  );

  tmr_flag_bank #(.W(1)) u_ovf_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_evt_i),
    .clr_i  (ovf_wclr | ovf_fclr),
    .q_o    (ovf_q)
  );

  assign ovf_flag_o = ovf_q[0];
  assign irq_any_o  = (|chan_flag_o) | ovf_q[0];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_ch)       rdata_o[NUM_CH-1:0] = chan_flag_o;
      else if (sel_ovf) rdata_o[OVF_POS]    = ovf_q[0];
    end
  end
endmodule

// File: rtl/tmr_flag_regs_chk.sv
module tmr_flag_regs_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NUM_CH-1:0] chan_evt_i,
  input logic              ovf_evt_i,
  input logic              tmr_en_i,
  input logic              fast_clr_i,
  input logic [NUM_CH-1:0] chan_flag_o,
  input logic              ovf_flag_o,
  input logic              irq_any_o
);
  AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_evt_i != '0) |=> ((chan_flag_o & $past(chan_evt_i)) == $past(chan_evt_i))); // R2
  AST_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_flag_o); // R10
  AST_OVF_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> $past(ovf_evt_i)); // R5
  AST_NO_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !fast_clr_i) |=> ((chan_flag_o & $past(chan_flag_o)) == $past(chan_flag_o))); // R4
  AST_OVF_NO_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !fast_clr_i && ovf_flag_o) |=> ovf_flag_o); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_any_o |-> (chan_flag_o == '0 && !ovf_flag_o)); // R11
  AST_OVF_RD_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(5'h0F)) |-> (rdata_o[DW-2:0] == '0)); // R5
  AST_IDLE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0)); // R12
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_evt_i == '0) |=> ((chan_flag_o & ~$past(chan_flag_o)) == '0)); // R2
endmodule

bind tmr_flag_regs tmr_flag_regs_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .rdata_o     (rdata_o),
  .chan_evt_i  (chan_evt_i),
  .ovf_evt_i   (ovf_evt_i),
  .tmr_en_i    (tmr_en_i),
  .fast_clr_i  (fast_clr_i),
  .chan_flag_o (chan_flag_o),
  .ovf_flag_o  (ovf_flag_o),
  .irq_any_o   (irq_any_o)
);

// File: tb/tmr_flag_regs_bench.sv
`timescale 1ns/1ps
module tmr_flag_regs_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] chan_evt_i = '0;
  logic       ovf_evt_i = 1'b0;
  logic [7:0] chan_is_cap_i = '0;
  logic       tmr_en_i = 1'b0, fast_clr_i = 1'b0;
  logic [7:0] chan_flag_o;
  logic       ovf_flag_o, irq_any_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tmr_flag_regs u_tmr_flag_regs (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o,
    .chan_evt_i, .ovf_evt_i, .chan_is_cap_i, .tmr_en_i, .fast_clr_i,
    .chan_flag_o, .ovf_flag_o, .irq_any_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus/event cycle, driven from a falling edge; returns same-cycle rdata
  task automatic cyc(input logic rd, input logic wr, input logic [4:0] a,
                     input logic [7:0] d, input logic [7:0] ev, input logic ov,
                     output logic [7:0] rv);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = d; chan_evt_i = ev; ovf_evt_i = ov;
    #1 rv = rdata_o;
    @(negedge clk_i);
    rd_i = 0; wr_i = 0; addr_i = '0; wdata_i = '0; chan_evt_i = '0; ovf_evt_i = 0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [7:0] v);
    cyc(1, 0, a, 8'h00, 8'h00, 0, v);
  endtask

  task automatic wrreg(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] v;
    cyc(0, 1, a, d, 8'h00, 0, v);
  endtask

  task automatic pulse(input logic [7:0] ev, input logic ov);
    logic [7:0] v;
    cyc(0, 0, 5'h00, 8'h00, ev, ov, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rdreg(5'h0E, v); chk("R1 ch flags", v, 8'h00);
    rdreg(5'h0F, v); chk("R1 ovf flag", v, 8'h00);
    chk("R1 irq", {7'b0, irq_any_o}, 8'h00);
  endtask

  task automatic t_set;
    logic [7:0] v;
    pulse(8'hA5, 0);
    rdreg(5'h0E, v); chk("R2 set by events", v, 8'hA5);
    chk("R2 status out", chan_flag_o, 8'hA5);
    rdreg(5'h0E, v); chk("R12 read no side effect", v, 8'hA5);
    rdreg(5'h03, v); chk("R12 other offset reads 0", v, 8'h00);
    chk("R11 irq set", {7'b0, irq_any_o}, 8'h01);
  endtask

  task automatic t_wclear;
    logic [7:0] v;
    tmr_en_i = 1;
    wrreg(5'h0E, 8'h05); rdreg(5'h0E, v); chk("R3 write-one clear", v, 8'hA0);
    wrreg(5'h0E, 8'h00); rdreg(5'h0E, v); chk("R3 write zero keeps", v, 8'hA0);
    tmr_en_i = 0;
    wrreg(5'h0E, 8'hFF); rdreg(5'h0E, v); chk("R4 disabled no clear", v, 8'hA0);
    tmr_en_i = 1;
    wrreg(5'h0E, 8'hFF); rdreg(5'h0E, v); chk("R3 clear all", v, 8'h00);
    chk("R11 irq low", {7'b0, irq_any_o}, 8'h00);
  endtask

  task automatic t_ovf;
    logic [7:0] v;
    pulse(8'h00, 1);
    rdreg(5'h0F, v); chk("R5 ovf set", v, 8'h80);
    chk("R11 irq from ovf", {7'b0, irq_any_o}, 8'h01);
    tmr_en_i = 0;
    wrreg(5'h0F, 8'h80); rdreg(5'h0F, v); chk("R4 disabled ovf no clear", v, 8'h80);
    tmr_en_i = 1;
    wrreg(5'h0F, 8'h7F); rdreg(5'h0F, v); chk("R6 bit7 zero keeps", v, 8'h80);
    wrreg(5'h0F, 8'h80); rdreg(5'h0F, v); chk("R6 ovf clear", v, 8'h00);
  endtask

  task automatic t_fast_cap;
    logic [7:0] v;
    tmr_en_i = 0;
    chan_is_cap_i = 8'h18;
    pulse(8'h18, 0);
    fast_clr_i = 0;
    rdreg(5'h16, v); rdreg(5'h0E, v); chk("R7 fast off no clear", v, 8'h18);
    fast_clr_i = 1;
    wrreg(5'h16, 8'h55); rdreg(5'h0E, v); chk("R7 capture write keeps", v, 8'h18);
    rdreg(5'h17, v); rdreg(5'h0E, v); chk("R7 capture read clears ch3", v, 8'h10);
  endtask

  task automatic t_fast_cmp;
    logic [7:0] v;
    chan_is_cap_i = 8'h00;
    rdreg(5'h18, v); rdreg(5'h0E, v); chk("R8 compare read keeps", v, 8'h10);
    wrreg(5'h19, 8'h01); rdreg(5'h0E, v); chk("R8 compare write clears ch4", v, 8'h00);
    pulse(8'h80, 0);
    wrreg(5'h1E, 8'h01); rdreg(5'h0E, v); chk("R8 ch7 low byte clears", v, 8'h00);
  endtask

  task automatic t_cnt;
    logic [7:0] v;
    pulse(8'h00, 1);
    fast_clr_i = 0;
    rdreg(5'h04, v); rdreg(5'h0F, v); chk("R9 fast off keeps ovf", v, 8'h80);
    fast_clr_i = 1;
    rdreg(5'h05, v); rdreg(5'h0F, v); chk("R9 counter read clears", v, 8'h00);
    pulse(8'h00, 1);
    wrreg(5'h04, 8'h12); rdreg(5'h0F, v); chk("R9 counter write clears", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    tmr_en_i = 1; fast_clr_i = 1;
    pulse(8'h01, 0);
    cyc(0, 1, 5'h0E, 8'h01, 8'h01, 0, v);
    rdreg(5'h0E, v); chk("R10 ch set beats write clear", v, 8'h01);
    pulse(8'h00, 1);
    cyc(1, 0, 5'h04, 8'h00, 8'h00, 1, v);
    rdreg(5'h0F, v); chk("R10 ovf set beats fast clear", v, 8'h80);
    chan_is_cap_i = 8'h01;
    cyc(1, 0, 5'h10, 8'h00, 8'h01, 0, v);
    rdreg(5'h0E, v); chk("R10 ch set beats fast clear", v, 8'h01);
    wrreg(5'h0E, 8'hFF); wrreg(5'h0F, 8'h80);
    chk("R11 all clear irq low", {7'b0, irq_any_o}, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset;
    t_set;
    t_wclear;
    t_ovf;
    t_fast_cap;
    t_fast_cmp;
    t_cnt;
    t_set_wins;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule